// File: doc/BRIEF.md
# Multi-mode bit scan unit

This execution unit sits in a processor datapath and answers five bit-position questions about a single operand word. A 3-bit operation code picks one of them: the number of zero bits above the highest set bit, the number of zero bits below the lowest set bit, the index of the lowest set bit, the index of the highest set bit, or the length of the run of bits under the top bit that copy the top bit. Each answer comes with a flag that marks an all-zero operand, which is also the case where the two index operations have no defined answer.

Every operation goes through one shared leading-zero counter. A transform stage in front of it picks what the counter sees: the operand itself, its bit mirror, its lowest set bit alone, or a word whose set bits mark where two neighbouring operand bits differ. A small correction stage after the counter subtracts from a fixed value or forces the result. One register stage holds the result. It loads only on a valid input, and its valid output trails the valid input by one clock.

Top module: `bitscan_unit`

## Requirements
- R1: Code 000 returns the number of zero bits above the highest set bit of the operand. An all-zero operand returns WIDTH.
- R2: Code 001 returns the number of zero bits below the lowest set bit. An all-zero operand returns WIDTH.
- R3: Code 010 with a nonzero operand returns the bit index (0 = least significant) of the lowest set bit.
- R4: Code 011 with a nonzero operand returns the bit index of the highest set bit, which equals (WIDTH-1) minus the code-000 count.
- R5: Codes 010 and 011 with an all-zero operand drive every bit of the result to 1 and raise the zero flag.
- R6: Code 100 returns how many bits, going down from bit WIDTH-2, match bit WIDTH-1 before the first bit that differs. An all-zero or all-ones operand returns WIDTH-1.
- R7: For codes 000 to 100 the zero flag is 1 exactly when the operand is all zeros. An all-ones operand under code 100 leaves it at 0.
- R8: Codes 101, 110 and 111 give a result of 0, a zero flag of 0 and an illegal-op output of 1. The illegal-op output is 0 for every other code.
- R9: Results and flags appear in the clock cycle after the cycle in which valid_in is sampled high, together with valid_out. valid_out is 1 only in those cycles.
- R10: In a cycle where valid_in is sampled low, result, zero flag and illegal-op output keep their values.
- R11: A synchronous active-high reset clears valid_out, the result and both flags, even if valid_in is high.
- R12: The result is $clog2(WIDTH)+1 bits wide so that the value WIDTH fits. WIDTH is a power of two from 8 to 64 and defaults to 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operation request for this cycle |
| op_in | input | 3 | Operation code |
| operand_in | input | WIDTH | Operand word |
| valid_out | output | 1 | Registered result is new this cycle |
| result_out | output | $clog2(WIDTH)+1 | Count or index |
| zero_flag_out | output | 1 | Operand was all zeros |
| illegal_out | output | 1 | Operation code was not recognised |

## Verification
The unit holds almost no state, so a fault in the transform, the shared counter or the correction shows up as a wrong value on result_out in the cycle right after the request. A fault in the single register shows up as a valid_out that is early, late or missing, or as a result that moves while no request is present. The scoreboard compares every completed request in its own cycle and checks the held value in every idle cycle. Walking-one and walking-zero operands reach each counter group and each mirrored bit position, and the all-zero and all-ones operands exercise the forced and saturated paths.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  // Operation codes on op_in
  localparam logic [2:0] OP_LEAD0   = 3'b000;
  localparam logic [2:0] OP_TRAIL0  = 3'b001;
  localparam logic [2:0] OP_FIRST1  = 3'b010;
  localparam logic [2:0] OP_LAST1   = 3'b011;
  localparam logic [2:0] OP_SIGNRUN = 3'b100;

  function automatic logic op_known(input logic [2:0] code);
    return code <= OP_SIGNRUN;
  endfunction

endpackage

// File: rtl/bscan_pretx.sv
module bscan_pretx
  import bscan_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [2:0]       op_sel,
  input  logic [WIDTH-1:0] word_in,
  output logic [WIDTH-1:0] core_vec
);

  logic [WIDTH-1:0] mirror_word;
  logic [WIDTH-1:0] lowest_only;
  logic [WIDTH-1:0] sign_diff;

  // bit mirror: trailing zeros become leading zeros
  for (genvar i = 0; i < WIDTH; i++) begin : g_mirror
    assign mirror_word[i] = word_in[WIDTH-1-i];
  end

  // keep only the lowest set bit
  assign lowest_only = word_in & (~word_in + WIDTH'(1));

  // bit k set where bits k and k+1 differ; top bit is always clear
  assign sign_diff = word_in ^ {word_in[WIDTH-1], word_in[WIDTH-1:1]};

  always_comb begin
    case (op_sel)
      OP_TRAIL0:  core_vec = mirror_word;
      OP_FIRST1:  core_vec = lowest_only;
      OP_SIGNRUN: core_vec = sign_diff;
      default:    core_vec = word_in;
    endcase
  end

endmodule

// File: rtl/bscan_lzc.sv
module bscan_lzc #(
  parameter int WIDTH = 32,
  parameter int GRP   = 4
) (
  input  logic [WIDTH-1:0]       vec_in,
  output logic [$clog2(WIDTH):0] zcount
);

  localparam int CW = $clog2(WIDTH) + 1;
  localparam int NG = WIDTH / GRP;
  localparam int GW = $clog2(GRP) + 1;

  logic [NG-1:0]    grp_nz;
  logic [NG*GW-1:0] grp_cnt;

  // group 0 holds the most significant bits
  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic [GRP-1:0] slice;
    logic [GW-1:0]  lcnt;
    assign slice     = vec_in[WIDTH-1-g*GRP -: GRP];
    assign grp_nz[g] = |slice;
    always_comb begin
      lcnt = GW'(GRP);
      for (int b = 0; b < GRP; b++) begin
        if (slice[b]) lcnt = GW'(GRP - 1 - b);
      end
    end
    assign grp_cnt[g*GW +: GW] = lcnt;
  end

  // the first nonzero group from the top decides the count
  always_comb begin
    zcount = CW'(WIDTH);
    for (int g = NG - 1; g >= 0; g--) begin
      if (grp_nz[g]) zcount = CW'(g * GRP) + CW'(grp_cnt[g*GW +: GW]);
    end
  end

endmodule

// File: rtl/bscan_post.sv
module bscan_post
  import bscan_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [2:0]             op_sel,
  input  logic [$clog2(WIDTH):0] core_cnt,
  input  logic                   src_zero,
  output logic [$clog2(WIDTH):0] res,
  output logic                   zflag,
  output logic                   bad_op
);

  localparam int CW = $clog2(WIDTH) + 1;
  localparam logic [CW-1:0] TOP_IDX = CW'(WIDTH - 1);

  always_comb begin
    res    = '0;
    zflag  = 1'b0;
    bad_op = 1'b0;
    case (op_sel)
      OP_LEAD0, OP_TRAIL0: begin
        res   = core_cnt;
        zflag = src_zero;
      end
      OP_FIRST1, OP_LAST1: begin
        res   = src_zero ? '1 : TOP_IDX - core_cnt;
        zflag = src_zero;
      end
      OP_SIGNRUN: begin
        res   = core_cnt - CW'(1);
        zflag = src_zero;
      end
      default: bad_op = 1'b1;
    endcase
  end

endmodule

// File: rtl/bitscan_unit.sv
module bitscan_unit
  import bscan_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   valid_in,
  input  logic [2:0]             op_in,
  input  logic [WIDTH-1:0]       operand_in,
  output logic                   valid_out,
  output logic [$clog2(WIDTH):0] result_out,
  output logic                   zero_flag_out,
  output logic                   illegal_out
);

  localparam int CW = $clog2(WIDTH) + 1;

  logic [WIDTH-1:0] core_vec;
  logic [CW-1:0]    core_cnt;
  logic [CW-1:0]    nxt_res;
  logic             nxt_zf;
  logic             nxt_ill;
  logic             operand_zero;

  assign operand_zero = ~|operand_in;

  bscan_pretx #(.WIDTH(WIDTH)) u_pretx (
    .op_sel   (op_in),
    .word_in  (operand_in),
    .core_vec (core_vec)
  );

  bscan_lzc #(.WIDTH(WIDTH), .GRP(4)) u_lzc (
    .vec_in (core_vec),
    .zcount (core_cnt)
  );

  bscan_post #(.WIDTH(WIDTH)) u_post (
    .op_sel   (op_in),
    .core_cnt (core_cnt),
    .src_zero (operand_zero),
    .res      (nxt_res),
    .zflag    (nxt_zf),
    .bad_op   (nxt_ill)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_out     <= 1'b0;
      result_out    <= '0;
      zero_flag_out <= 1'b0;
      illegal_out   <= 1'b0;
    end else begin
      valid_out <= valid_in;
      if (valid_in) begin
        result_out    <= nxt_res;
        zero_flag_out <= nxt_zf;
        illegal_out   <= nxt_ill;
      end
    end
  end

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> valid_out);
  // R9
  valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> !valid_out);
  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> $stable(result_out) && $stable(zero_flag_out) && $stable(illegal_out));
  // R1
  top_set_lead_chk: assert property (@(posedge clk) disable iff (rst)
    valid_in && op_in == OP_LEAD0 && operand_in[WIDTH-1] |=> result_out == '0);
  // R2
  low_set_trail_chk: assert property (@(posedge clk) disable iff (rst)
    valid_in && op_in == OP_TRAIL0 && operand_in[0] |=> result_out == '0);
  // R5
  undef_ones_chk: assert property (@(posedge clk) disable iff (rst)
    valid_in && (op_in == OP_FIRST1 || op_in == OP_LAST1) && operand_in == '0
    |=> (&result_out) && zero_flag_out);
  // R6
  sign_sat_chk: assert property (@(posedge clk) disable iff (rst)
    valid_in && op_in == OP_SIGNRUN && (operand_in == '0 || operand_in == '1)
    |=> result_out == CW'(WIDTH - 1));
  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    valid_in && op_known(op_in) |=> zero_flag_out == $past(operand_zero));
  // R8
  illegal_code_chk: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> illegal_out == !op_known($past(op_in)));
  // R8
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    valid_out && illegal_out |-> result_out == '0 && !zero_flag_out);
  // R1
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    valid_out && !zero_flag_out && !illegal_out |-> result_out < CW'(WIDTH));

endmodule

// File: tb/tb_bitscan_unit.sv
module tb_bitscan_unit;
  localparam int W  = 32;
  localparam int CW = $clog2(W) + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          valid_in = 1'b0;
  logic [2:0]    op_in = 3'b000;
  logic [W-1:0]  operand_in = '0;
  logic          valid_out;
  logic [CW-1:0] result_out;
  logic          zero_flag_out;
  logic          illegal_out;

  bitscan_unit #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .valid_in(valid_in), .op_in(op_in),
    .operand_in(operand_in), .valid_out(valid_out), .result_out(result_out),
    .zero_flag_out(zero_flag_out), .illegal_out(illegal_out)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [CW-1:0] res;
    logic          zf;
    logic          ill;
    string         tag;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad   = 0;
  bit   done  = 0;

  function automatic int ref_lead(input logic [W-1:0] x);
    int n = 0;
    for (int i = W - 1; i >= 0; i--) begin
      if (x[i]) break;
      n++;
    end
    return n;
  endfunction

  function automatic int ref_trail(input logic [W-1:0] x);
    int n = 0;
    for (int i = 0; i < W; i++) begin
      if (x[i]) break;
      n++;
    end
    return n;
  endfunction

  function automatic int ref_sign(input logic [W-1:0] x);
    int n = 0;
    for (int i = W - 2; i >= 0; i--) begin
      if (x[i] != x[W-1]) break;
      n++;
    end
    return n;
  endfunction

  function automatic exp_t model(input logic [2:0] op, input logic [W-1:0] x);
    exp_t e;
    e.res = '0; e.zf = (x == '0); e.ill = 1'b0;
    case (op)
      3'b000: begin e.res = CW'(ref_lead(x));  e.tag = e.zf ? "R1 R7" : "R1"; end
      3'b001: begin e.res = CW'(ref_trail(x)); e.tag = e.zf ? "R2 R7" : "R2"; end
      3'b010: begin
        e.res = e.zf ? '1 : CW'(ref_trail(x));
        e.tag = e.zf ? "R5 R7" : "R3";
      end
      3'b011: begin
        e.res = e.zf ? '1 : CW'(W - 1 - ref_lead(x));
        e.tag = e.zf ? "R5 R7" : "R4";
      end
      3'b100: begin e.res = CW'(ref_sign(x)); e.tag = e.zf ? "R6 R7" : "R6"; end
      default: begin e.res = '0; e.zf = 1'b0; e.ill = 1'b1; e.tag = "R8"; end
    endcase
    return e;
  endfunction

  task automatic send(input logic [2:0] op, input logic [W-1:0] x);
    q.push_back(model(op, x));
    @(negedge clk);
    valid_in   = 1'b1;
    op_in      = op;
    operand_in = x;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_in   = 1'b0;
      operand_in = $urandom;
      op_in      = 3'($urandom);
    end
  endtask

  task automatic check_clear(input string tag);
    total++;
    if (valid_out !== 1'b0 || result_out !== '0 || zero_flag_out !== 1'b0 || illegal_out !== 1'b0) begin
      bad++;
      $display("FAIL %s: reset state got v=%0b res=%0d zf=%0b ill=%0b, expected all 0",
               tag, valid_out, result_out, zero_flag_out, illegal_out);
    end
  endtask

  // scoreboard monitor
  initial begin : monitor
    logic [CW+1:0] last;
    last = '0;
    forever begin
      @(posedge clk);
      #1;
      if (rst) begin
        last = '0;
      end else if (valid_out) begin
        total++;
        if (q.size() == 0) begin
          bad++;
          $display("FAIL R9: valid_out=1 with no request, expected valid_out=0");
        end else begin
          exp_t e;
          e = q.pop_front();
          if (result_out !== e.res || zero_flag_out !== e.zf || illegal_out !== e.ill) begin
            bad++;
            $display("FAIL %s: got res=%0d zf=%0b ill=%0b, expected res=%0d zf=%0b ill=%0b",
                     e.tag, result_out, zero_flag_out, illegal_out, e.res, e.zf, e.ill);
          end
        end
        last = {result_out, zero_flag_out, illegal_out};
      end else begin
        total++;
        if ({result_out, zero_flag_out, illegal_out} !== last) begin
          bad++;
          $display("FAIL R10: idle cycle got %0h, expected held %0h",
                   {result_out, zero_flag_out, illegal_out}, last);
        end
      end
    end
  end

  initial begin : watchdog
    #(60000 * 10);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [W-1:0] pats [10];
    pats = '{32'h0, 32'hFFFF_FFFF, 32'h1, 32'h8000_0000, 32'h0001_0000,
             32'h00F0_0000, 32'h8000_0001, 32'h7FFF_FFFF, 32'hFFFF_FFFE, 32'h0000_3800};
    repeat (3) @(negedge clk);
    check_clear("R11");
    rst = 1'b0;

    // every code against fixed patterns, R12: count W must fit
    for (int op = 0; op < 8; op++) begin
      for (int p = 0; p < 10; p++) send(3'(op), pats[p]);
    end
    idle(2);

    // walking one through every bit position
    for (int op = 0; op < 5; op++) begin
      for (int b = 0; b < W; b++) send(3'(op), W'(1) << b);
      idle(1);
    end
    // walking zero, exercising sign runs and top-zero counts
    for (int b = 0; b < W; b++) send(3'b100, ~(W'(1) << b));
    for (int b = 0; b < W; b++) send(3'b000, ~(W'(1) << b));
    idle(3);

    // random operands with varied magnitude and gaps
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] x;
      x = W'($urandom) >> ($urandom % W);
      if ($urandom % 4 == 0) x = ~x;
      send(3'($urandom), x);
      if ($urandom % 5 == 0) idle(1 + $urandom % 3);
    end
    idle(3);

    // reset with an input request present
    send(3'b000, 32'h1);
    @(negedge clk);
    valid_in = 1'b1;
    rst      = 1'b1;
    @(posedge clk);
    #1;
    check_clear("R11");
    @(negedge clk);
    valid_in = 1'b0;
    rst      = 1'b0;
    idle(2);

    send(3'b011, 32'h0);
    idle(3);

    total++;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL R9: %0d requests without a result, expected 0", q.size());
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule